// File: doc/BRIEF.md
# Filtered reset conditioner

This block turns a raw, active-high reset arriving from the board into clean reset copies for the logic of one clock domain. The raw level first crosses a two-flop synchronizer. A run-length filter then follows, which ignores any pulse that is too short to be a real reset request. The same filter also ignores short dropouts while reset is asserted, so the release cannot chatter. One instance serves a whole region of the chip. Its result is driven out as several register copies that always agree, so that each copy feeds only a bounded share of the loads.

A strap input selects the mode. With the strap high the filter is active. With the strap low the block behaves as a plain two-stage synchronizer. The filter length `FILT_LEN` (N) and the number of copies `COPIES` are parameters. The block has no reset input of its own: every register powers up in the asserted state.

Top module: `reset_conditioner`

## Requirements
- R1: At power-up, before any clock edge and after the first one while the raw input is high, every output copy is 1, meaning reset is asserted.
- R2: With `filt_en_i` low, each output copy equals the raw input as it was two clock edges earlier. This holds for both the rising and the falling transition. A pulse of K cycles appears at the output as a pulse of K cycles.
- R3: With `filt_en_i` high, a high pulse on the raw input lasting N cycles or fewer leaves all outputs low. With the default N of 2, this covers pulses of 1 and 2 cycles.
- R4: With `filt_en_i` high, a high pulse lasting N+1 cycles or more asserts the outputs. They rise N+3 clock edges after the raw input rises, which is 5 edges with the default N. They stay high for as many cycles as the pulse lasted.
- R5: With `filt_en_i` high and reset asserted, a low dropout lasting N cycles or fewer leaves all outputs high. A longer low period releases the outputs N+3 edges after the raw input falls.
- R6: All `COPIES` output bits carry the same value on every cycle. Each bit comes from its own register.
- R7: With `filt_en_i` high, the filtered state changes only after the synchronized input has disagreed with it for at least N consecutive earlier samples. The new state always equals the synchronized input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the domain being reset |
| rst_raw_i | input | 1 | Raw asynchronous reset, active high |
| filt_en_i | input | 1 | Strap: 1 enables the glitch filter, 0 selects plain synchronization |
| rst_o | output | COPIES | Replicated conditioned reset, active high |

## Verification
The checker watches three things on every cycle. It confirms that all copies agree. It confirms that, in plain mode, the outputs track the raw input delayed by two edges. It confirms that, in filtered mode, every output change is preceded by a long enough run of disagreeing synchronized samples and lands on the synchronized value. The exact latencies of N+3 edges, the rejection of 1- and 2-cycle glitches in both polarities, the preserved pulse width and the power-up value are shown only by the bench's sweeps of pulse width in both modes and both polarities.

// File: rtl/reset_conditioner.sv
module reset_conditioner #(
  parameter int FILT_LEN = 2,
  parameter int COPIES   = 4
) (
  input  logic              clk,
  input  logic              rst_raw_i,
  input  logic              filt_en_i,
  output logic [COPIES-1:0] rst_o
);
  localparam int CW = $clog2(FILT_LEN + 2);

  logic [1:0]    sync_q = 2'b11;
  logic [CW-1:0] run_q  = '0;
  logic          held_q = 1'b1;

  wire differ   = sync_q[1] ^ held_q;
  wire at_limit = (run_q == CW'(FILT_LEN));
  wire filt_nxt = (differ && at_limit) ? sync_q[1] : held_q;
  wire copy_nxt = filt_en_i ? filt_nxt : sync_q[0];

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[0], rst_raw_i};
    held_q <= copy_nxt;
    if (filt_en_i && differ && !at_limit) run_q <= run_q + 1'b1;
    else                                  run_q <= '0;
  end

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    logic q = 1'b1;
    always_ff @(posedge clk) q <= copy_nxt;
    assign rst_o[g] = q;
  end
endmodule

module reset_conditioner_chk #(
  parameter int FILT_LEN = 2,
  parameter int COPIES   = 4
) (
  input logic              clk,
  input logic              raw,
  input logic              filt_en,
  input logic              sync_b,
  input logic [COPIES-1:0] rst
);
  localparam int RW = $clog2(FILT_LEN + 3);

  logic [1:0]    armed_q = 2'd0;
  logic [RW-1:0] run_c   = '0;

  always_ff @(posedge clk) begin
    if (armed_q != 2'd3) armed_q <= armed_q + 2'd1;
    if (filt_en && (sync_b != rst[0]))
      run_c <= (run_c == RW'(FILT_LEN + 1)) ? run_c : run_c + 1'b1;
    else
      run_c <= '0;
  end

  always @(negedge clk)
    if (armed_q != 2'd0)
      p_copies_equal_r6: assert ((&rst) || !(|rst));

  p_plain_latency_r2: assert property (@(posedge clk) disable iff (armed_q != 2'd3)
    !$past(filt_en) |-> (rst[0] == $past(raw, 2)));

  p_filter_run_r7: assert property (@(posedge clk) disable iff (armed_q != 2'd3)
    ($past(filt_en) && (rst[0] != $past(rst[0]))) |-> ($past(run_c) >= RW'(FILT_LEN)));

  p_filter_target_r7: assert property (@(posedge clk) disable iff (armed_q != 2'd3)
    ($past(filt_en) && (rst[0] != $past(rst[0]))) |-> (rst[0] == $past(sync_b)));

  p_glitch_hold_r3: assert property (@(posedge clk) disable iff (armed_q != 2'd3)
    ($past(filt_en) && ($past(run_c) < RW'(FILT_LEN))) |-> $stable(rst[0]));
endmodule

bind reset_conditioner reset_conditioner_chk #(.FILT_LEN(FILT_LEN), .COPIES(COPIES)) u_chk (
  .clk(clk), .raw(rst_raw_i), .filt_en(filt_en_i), .sync_b(sync_q[1]), .rst(rst_o)
);

// File: tb/reset_conditioner_tb.sv
module reset_conditioner_tb;
  localparam int N = 2;
  localparam int C = 4;

  logic clk = 1'b0;
  logic raw = 1'b1;
  logic fen = 1'b1;
  logic [C-1:0] rst;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  reset_conditioner #(.FILT_LEN(N), .COPIES(C)) u_dut (
    .clk(clk), .rst_raw_i(raw), .filt_en_i(fen), .rst_o(rst)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic trial(input bit filt, input bit lvl, input int k);
    int first = 0;
    int cnt = 0;
    bit agree = 1'b1;
    int exp_first, exp_cnt;
    string tag;
    fen = filt;
    raw = ~lvl;
    repeat (12) @(negedge clk);
    check("R6 settled", int'(rst), lvl ? 0 : (1 << C) - 1);
    raw = lvl;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (!((&rst) || !(|rst))) agree = 1'b0;
      if (rst[0] == lvl) begin
        cnt++;
        if (first == 0) first = i;
      end
      if (i == k) raw = ~lvl;
    end
    if (!filt) begin
      exp_first = 2; exp_cnt = k; tag = "R2";
    end else if (k <= N) begin
      exp_first = 0; exp_cnt = 0; tag = lvl ? "R3" : "R5";
    end else begin
      exp_first = N + 3; exp_cnt = k; tag = lvl ? "R4" : "R5";
    end
    check($sformatf("%s first edge f=%0d l=%0d k=%0d", tag, filt, lvl, k), first, exp_first);
    check($sformatf("%s width f=%0d l=%0d k=%0d", tag, filt, lvl, k), cnt, exp_cnt);
    check("R6 copies agree", int'(agree), 1);
  endtask

  initial begin
    #1;
    check("R1 before first edge", int'(rst), (1 << C) - 1);
    @(negedge clk);
    check("R1 after first edge", int'(rst), (1 << C) - 1);
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 2; l++)
        for (int k = 1; k <= 7; k++)
          trial(f[0], l[0], k);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule